// File: doc/BRIEF.md
# Bank-Split Synchronous Word Memory

This block presents one synchronous single-port word memory to its user and builds it from two equal banks. Each access is routed to exactly one bank, so only half of the storage array is enabled on any cycle. This lowers the energy spent per access, while the user still sees one flat address space. The low-order address bit picks the bank and the remaining upper bits give the word index inside that bank. Write data and the write strobe are wired to both banks, but only the addressed bank acts on them.

A read is issued by holding `rd_en` high for one clock with the address. The bank captures the word on that edge. A registered copy of the bank-select bit then steers the output multiplexer, so `rd_data` carries the word from the next clock edge on. A small access tracker has three states, named for the operation sampled on the last edge: `ACC_IDLE`, `ACC_READ` and `ACC_WRITE`. Its transitions are simple. A cycle with `wr_en` high goes to `ACC_WRITE`. A cycle with only `rd_en` high goes to `ACC_READ`. A cycle with neither goes to `ACC_IDLE`. Reset also forces `ACC_IDLE`. Only in `ACC_READ` does the output take fresh bank data. In the other states it repeats the last value it showed.

The bank-select width, data width and total address width are parameters. The defaults give a compact 2K-word instance for elaboration. The full-size arrangement is two 16K x 32 banks on a 15-bit address, obtained with `ADDR_W = 15`.

Top module: `split_bank_mem`

## Requirements
- R1: Every address in the range 0 to 2**ADDR_W-1 stores its own word. The bank is chosen by address bits [BSEL_W-1:0] (bit 0 by default), and the bits above them form the word index inside the bank.
- R2: When `rd_en` is high and `wr_en` is low at a rising edge, `rd_data` shows the stored word at that address after that same edge, which is one cycle after the request.
- R3: On a read or write, exactly one bank is enabled, and it is the bank named by the low address bit(s). On a cycle with no access, no bank is enabled.
- R4: A write changes only the addressed word. The word with the same index in the other bank keeps its value.
- R5: After an edge where no read was taken (idle or write), `rd_data` keeps the value it had before that edge.
- R6: A read of an address in the cycle directly after a write to that address returns the newly written data.
- R7: When `wr_en` and `rd_en` are both high, the write is performed and the read is dropped, so `rd_data` holds its previous value.
- R8: While reset (`rst_n` low) is applied and after it is released, `rd_data` is zero until the first read completes.
- R9: Back-to-back reads that alternate between banks each return their own word. The output selection follows the registered bank bit of the matching request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address; low bit(s) pick the bank |
| wr_en | input | 1 | Write strobe; has priority over `rd_en` |
| wr_data | input | DATA_W | Data to store on a write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Read word, valid from the edge after the read |

## Verification
Every read result is due one clock after the edge that samples the request. Inputs are driven on the falling edge, and `rd_data` is compared on the next falling edge, half a period after the edge that produced it. The bench keeps a model of the expected output. A read loads that model from the bench's own word array. Writes and idle cycles leave it unchanged. As a result, each falling-edge check also tests the hold rule for cycles without a read. Write-then-read and dual-strobe sequences are placed on consecutive cycles so that the one-cycle timing is checked with no gap between operations.

// File: rtl/split_bank_mem_pkg.sv
package split_bank_mem_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    function automatic acc_e classify(input logic wr, input logic rd);
        if (wr)      return ACC_WRITE;
        else if (rd) return ACC_READ;
        else         return ACC_IDLE;
    endfunction

endpackage

// File: rtl/split_bank_decode.sv
module split_bank_decode
    import split_bank_mem_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BSEL_W = 1,
    localparam int NBANK = 1 << BSEL_W,
    localparam int IDX_W = ADDR_W - BSEL_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output acc_e              cmd,
    output logic [BSEL_W-1:0] bank_sel,
    output logic [IDX_W-1:0]  word_idx,
    output logic [NBANK-1:0]  bank_ce,
    output logic [NBANK-1:0]  bank_we
);

    assign cmd      = classify(wr_en, rd_en);
    assign bank_sel = addr[BSEL_W-1:0];
    assign word_idx = addr[ADDR_W-1:BSEL_W];

    for (genvar b = 0; b < NBANK; b++) begin : g_dec
        logic hit;
        assign hit        = (bank_sel == BSEL_W'(b));
        assign bank_ce[b] = hit && (cmd != ACC_IDLE);
        assign bank_we[b] = hit && (cmd == ACC_WRITE);
    end

endmodule

// File: rtl/split_bank_ram.sv
module split_bank_ram #(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (ce && we) begin
            mem[idx] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (ce && !we) begin
            dout <= mem[idx];
        end
    end

endmodule

// File: rtl/split_bank_ctrl.sv
module split_bank_ctrl
    import split_bank_mem_pkg::*;
#(
    parameter int BSEL_W = 1,
    parameter int DATA_W = 32,
    localparam int NBANK = 1 << BSEL_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  acc_e                          cmd,
    input  logic [BSEL_W-1:0]             bank_sel,
    input  logic [NBANK-1:0][DATA_W-1:0]  bank_dout,
    output acc_e                          state_q,
    output logic [BSEL_W-1:0]             sel_q,
    output logic [DATA_W-1:0]             rd_data
);

    logic [DATA_W-1:0] hold_q;
    logic              sel_load;

    always_comb begin
        sel_load = 1'b0;
        unique case (cmd)
            ACC_READ:  sel_load = 1'b1;
            ACC_WRITE: sel_load = 1'b0;
            ACC_IDLE:  sel_load = 1'b0;
            default:   sel_load = 1'b0;
        endcase
    end

    // state register: the operation taken on the last edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= cmd;
            if (sel_load) begin
                sel_q <= bank_sel;
            end
        end
    end

    // outputs: fresh bank word only after a read, else repeat
    always_comb begin
        rd_data = hold_q;
        unique case (state_q)
            ACC_READ:  rd_data = bank_dout[sel_q];
            ACC_WRITE: rd_data = hold_q;
            ACC_IDLE:  rd_data = hold_q;
            default:   rd_data = hold_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= rd_data;
        end
    end

endmodule

// File: rtl/split_bank_mem.sv
module split_bank_mem
    import split_bank_mem_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32,
    parameter int BSEL_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NBANK = 1 << BSEL_W;
    localparam int IDX_W = ADDR_W - BSEL_W;

    acc_e                         cmd;
    acc_e                         state_q;
    logic [BSEL_W-1:0]            bank_sel;
    logic [BSEL_W-1:0]            sel_q;
    logic [IDX_W-1:0]             word_idx;
    logic [NBANK-1:0]             bank_ce;
    logic [NBANK-1:0]             bank_we;
    logic [NBANK-1:0][DATA_W-1:0] bank_dout;

    split_bank_decode #(.ADDR_W(ADDR_W), .BSEL_W(BSEL_W)) u_dec (
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .cmd      (cmd),
        .bank_sel (bank_sel),
        .word_idx (word_idx),
        .bank_ce  (bank_ce),
        .bank_we  (bank_we)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        split_bank_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .ce    (bank_ce[b]),
            .we    (bank_we[b]),
            .idx   (word_idx),
            .din   (wr_data),
            .dout  (bank_dout[b])
        );
    end

    split_bank_ctrl #(.BSEL_W(BSEL_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .bank_sel  (bank_sel),
        .bank_dout (bank_dout),
        .state_q   (state_q),
        .sel_q     (sel_q),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/split_bank_mem_chk.sv
module split_bank_mem_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32,
    parameter int BSEL_W = 1,
    localparam int NBANK = 1 << BSEL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [NBANK-1:0]  bank_ce,
    input logic [NBANK-1:0]  bank_we,
    input logic [BSEL_W-1:0] sel_q
);

    // R3
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_ce));

    // R3
    addressed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) |-> ($countones(bank_ce) == 1 && bank_ce[addr[BSEL_W-1:0]]));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |-> (bank_ce == '0));

    // R4
    write_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (bank_we == bank_ce));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> $stable(rd_data));

    // R9
    sel_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> (sel_q == $past(addr[BSEL_W-1:0])));

endmodule

bind split_bank_mem split_bank_mem_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BSEL_W(BSEL_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .bank_ce (bank_ce),
    .bank_we (bank_we),
    .sel_q   (sel_q)
);

// File: tb/split_bank_mem_tb.sv
module split_bank_mem_tb;

    localparam int ADDR_W  = 11;
    localparam int DATA_W  = 32;
    localparam int WORDS   = 1 << ADDR_W;
    localparam int CLK_PER = 10;
    localparam int WD_MAX  = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [DATA_W-1:0] model [WORDS];
    logic [DATA_W-1:0] exp_q = '0;
    string             last_tag = "R8";

    always #(CLK_PER/2) clk = ~clk;

    split_bank_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BSEL_W(1)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    function automatic logic [DATA_W-1:0] pat(input int a, input int salt);
        return DATA_W'((a * 32'h9E3779B1) ^ (salt * 32'h85EBCA6B) ^ 32'h5A5A0F0F);
    endfunction

    task automatic check(input string tag, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s rd_data=%h expected %h at %0t", tag, rd_data, exp, $time);
        end
    endtask

    // One clock: check result of previous op, then apply a new one.
    task automatic cyc(input bit we, input bit re, input int a,
                       input logic [DATA_W-1:0] d, input string tag);
        @(negedge clk);
        check(last_tag, exp_q);
        wr_en   = we;
        rd_en   = re;
        addr    = ADDR_W'(a);
        wr_data = d;
        if (we)      model[a] = d;      // R7: write wins, no read
        else if (re) exp_q = model[a];  // R2: due after next edge
        last_tag = tag;
    endtask

    initial begin : watchdog
        int n = 0;
        while (!finished && n < WD_MAX) begin
            @(posedge clk);
            n++;
        end
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        // R8: reset value
        repeat (3) @(negedge clk);
        check("R8", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", '0);

        // R1: fill every address, rd_data holds zero during writes (R5)
        for (int a = 0; a < WORDS; a++) cyc(1, 0, a, pat(a, 1), "R5");
        // R1 and R9: back-to-back reads alternate banks
        for (int a = 0; a < WORDS; a++) cyc(0, 1, a, '0, "R1");
        for (int a = WORDS - 1; a >= 0; a--) cyc(0, 1, a, '0, "R9");

        // R4: write even word, odd neighbour with same index unchanged
        cyc(1, 0, 10, 32'hDEAD_0010, "R5");
        cyc(0, 1, 11, '0, "R4");
        cyc(0, 1, 10, '0, "R4");
        cyc(1, 0, 301, 32'hBEEF_0301, "R5");
        cyc(0, 1, 300, '0, "R4");
        cyc(0, 1, 301, '0, "R4");

        // R6: read right after write to same address, both banks
        cyc(1, 0, 77, 32'h1234_5678, "R5");
        cyc(0, 1, 77, '0, "R6");
        cyc(1, 0, 78, 32'h8765_4321, "R5");
        cyc(0, 1, 78, '0, "R6");

        // R7: both strobes high; output holds then new data readable
        cyc(0, 1, 5, '0, "R2");
        cyc(1, 1, 5, 32'hCAFE_F00D, "R7");
        cyc(0, 0, 0, '0, "R7");
        cyc(0, 1, 5, '0, "R7");

        // R5: idle cycles keep last read word
        for (int i = 0; i < 4; i++) cyc(0, 0, i, 32'hFFFF_FFFF, "R5");

        // R2: constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            int a;
            r = int'($urandom_range(0, 9));
            a = int'($urandom_range(0, WORDS - 1));
            if (r < 3)      cyc(1, 0, a, $urandom(), "R5");
            else if (r < 8) cyc(0, 1, a, '0, "R2");
            else if (r < 9) cyc(1, 1, a, $urandom(), "R7");
            else            cyc(0, 0, a, $urandom(), "R5");
        end
        cyc(0, 0, 0, '0, "R5");
        @(negedge clk);
        check(last_tag, exp_q);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule